// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Guard

This block sits beside the bus state machine of an SMBus target and measures how long the host keeps the clock line low. It first passes the raw clock and data lines through a two-stage synchronizer and hands the clean copies to the protocol engine. It then counts system clock cycles while the synchronized clock stays low. If the low time goes past a threshold derived from the system clock frequency, the block issues a one-cycle bus-reset pulse. That pulse returns the target's state machine to idle. The block also raises an override that forces the target's data driver off, so a stalled transfer cannot hold the bus.

The target never drives the clock line, so the block has no clock output and cannot stretch the clock. A disable input, fed from a bit in the target's configuration register, turns detection off while it is 1. That register bit resets to 0, so detection is on after reset. With detection on, the slowest bus clock the target supports is 10 kHz.

Top module: `smb_lowtime_guard`

## Requirements
- R1: `scl_sync_o` and `sda_sync_o` equal `scl_i` and `sda_i` delayed by exactly two clock cycles. Both synchronizer stages reset to 1, which is the idle level of the bus.
- R2: The threshold LIM is (CLK_HZ/1000)*TIMEOUT_MS cycles. `bus_rst_o` is high for one cycle when the synchronized clock has been low for more than LIM consecutive cycles. A low run of exactly LIM cycles produces no pulse; a run of LIM+1 cycles produces one.
- R3: The low-time counter saturates at LIM instead of wrapping. However long the clock stays low, a timeout event produces exactly one pulse.
- R4: `sda_rel_o` goes high in the same cycle as the bus-reset pulse. It stays high until the cycle after the synchronized clock is seen high.
- R5: While `to_dis` is 1, no pulse is issued, the counter is held at zero and `sda_rel_o` is low.
- R6: Each high level of the synchronized clock restarts the low-time count from zero. Two low runs of LIM cycles each, separated by a short high phase, produce no pulse.
- R7: After reset, `bus_rst_o` and `sda_rel_o` are low and both synchronized outputs are 1.
- R8: Once the clock has gone high after a timeout, a new low run of more than LIM cycles produces a new pulse.
- R9: Setting `to_dis` while the release override is active clears the override in the next cycle. Clearing `to_dis` again while the clock is still low does not issue a second pulse for the same event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| to_dis | input | 1 | Timeout disable from the configuration register, 1 = off |
| scl_sync_o | output | 1 | Synchronized clock line for the protocol engine |
| sda_sync_o | output | 1 | Synchronized data line for the protocol engine |
| bus_rst_o | output | 1 | One-cycle pulse that returns the target FSM to idle |
| sda_rel_o | output | 1 | Override that forces the target's data driver off |

## Verification
Two events can fall on the same cycle. The counter can reach its threshold in the very cycle the synchronized clock returns high. The disable bit can also change in the cycle a timeout would fire. The bench provokes both collisions by holding the clock low for exactly LIM and LIM+1 cycles, and by raising `to_dis` while a release is active. A behavioural model counts low runs with plain integers, and every cycle it decides which of the colliding events wins. The bench compares the pulse and the release against that model on every clock.

// File: rtl/smb_to_pkg.sv
package smb_to_pkg;

  // Number of system clock cycles in the timeout window.
  function automatic int unsigned calc_limit(input int unsigned clk_hz,
                                             input int unsigned win_ms);
    return (clk_hz / 1000) * win_ms;
  endfunction

  // Counter width that can hold the value lim.
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/smb_sync2.sv
module smb_sync2 #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/smb_low_counter.sv
module smb_low_counter #(
  parameter int unsigned LIM = 350,
  parameter int unsigned CW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          dis,
  output logic [CW-1:0] cnt_o,
  output logic          sat_o
);
  localparam logic [CW-1:0] LIM_V = CW'(LIM);

  logic [CW-1:0] cnt_q;

  assign sat_o = (cnt_q == LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (dis || scl_s)  cnt_q <= '0;
    else if (!sat_o)        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/smb_rst_gen.sv
module smb_rst_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic dis,
  input  logic hit,
  output logic pulse_o,
  output logic rel_o,
  output logic fired_o
);
  logic fired_q, pulse_q, rel_q;
  logic new_evt;

  assign new_evt = hit && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      pulse_q <= new_evt;
      if (scl_s)      fired_q <= 1'b0;
      else if (hit)   fired_q <= 1'b1;
      if (scl_s || dis) rel_q <= 1'b0;
      else if (new_evt) rel_q <= 1'b1;
    end
  end

  assign pulse_o = pulse_q;
  assign rel_o   = rel_q;
  assign fired_o = fired_q;
endmodule

// File: rtl/smb_lowtime_guard.sv
module smb_lowtime_guard #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned TIMEOUT_MS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic to_dis,
  output logic scl_sync_o,
  output logic sda_sync_o,
  output logic bus_rst_o,
  output logic sda_rel_o
);
  import smb_to_pkg::*;

  localparam int unsigned LIM = calc_limit(CLK_HZ, TIMEOUT_MS);
  localparam int unsigned CW  = cnt_bits(LIM);

  logic [1:0]    sync_q;
  logic          scl_s;
  logic [CW-1:0] low_cnt;
  logic          cnt_sat;
  logic          to_hit;
  logic          evt_fired;

  smb_sync2 #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sda_i, scl_i}), .q_o(sync_q)
  );

  assign scl_s = sync_q[0];

  smb_low_counter #(.LIM(LIM), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .dis(to_dis),
    .cnt_o(low_cnt), .sat_o(cnt_sat)
  );

  assign to_hit = cnt_sat && !scl_s && !to_dis;

  smb_rst_gen u_gen (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .dis(to_dis), .hit(to_hit),
    .pulse_o(bus_rst_o), .rel_o(sda_rel_o), .fired_o(evt_fired)
  );

  assign scl_sync_o = scl_s;
  assign sda_sync_o = sync_q[1];
endmodule

// File: rtl/smb_guard_chk.sv
module smb_guard_chk #(
  parameter int unsigned CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_sync_o,
  input logic          to_dis,
  input logic          bus_rst_o,
  input logic          sda_rel_o,
  input logic          cnt_sat,
  input logic [CW-1:0] low_cnt
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |=> !bus_rst_o);

  p_pulse_after_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |-> $past(cnt_sat));

  p_release_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_o |-> sda_rel_o);

  p_release_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_sync_o |=> !sda_rel_o);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    to_dis |=> (!bus_rst_o && !sda_rel_o));

  p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_sync_o |=> (low_cnt == '0));
endmodule

bind smb_lowtime_guard smb_guard_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync_o(scl_sync_o), .to_dis(to_dis),
  .bus_rst_o(bus_rst_o), .sda_rel_o(sda_rel_o), .cnt_sat(cnt_sat),
  .low_cnt(low_cnt)
);

// File: tb/tb_smb_lowtime_guard.sv
`timescale 1ns/1ps
module tb_smb_lowtime_guard;
  localparam int unsigned TB_HZ = 10_000;
  localparam int unsigned TB_MS = 35;
  localparam int LIM = (TB_HZ / 1000) * TB_MS;   // 350 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, to_dis = 1'b0;
  logic scl_sync_o, sda_sync_o, bus_rst_o, sda_rel_o;

  int n_tests = 0, n_fail = 0, n_pulse = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  int m_s1 = 1, m_s2 = 1, m_d1 = 1, m_d2 = 1;
  int m_run = 0, m_fired = 0, m_pulse = 0, m_rel = 0;

  always #5 clk = ~clk;

  smb_lowtime_guard #(.CLK_HZ(TB_HZ), .TIMEOUT_MS(TB_MS)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .to_dis(to_dis),
    .scl_sync_o(scl_sync_o), .sda_sync_o(sda_sync_o),
    .bus_rst_o(bus_rst_o), .sda_rel_o(sda_rel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int hit, np, nf, nr, nrun;
    cyc++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_d1 = 1; m_d2 = 1;
      m_run = 0; m_fired = 0; m_pulse = 0; m_rel = 0;
    end else begin
      hit  = (m_s2 == 0 && !to_dis && m_run >= LIM);
      np   = hit && !m_fired;
      nrun = (to_dis || m_s2) ? 0 : m_run + 1;
      nf   = m_s2 ? 0 : (hit ? 1 : m_fired);
      nr   = (m_s2 || to_dis) ? 0 : (np ? 1 : m_rel);
      m_s2 = m_s1; m_s1 = scl_i; m_d2 = m_d1; m_d1 = sda_i;
      m_run = nrun; m_fired = nf; m_pulse = np; m_rel = nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 scl sync", scl_sync_o, m_s2);
      chk("R1 sda sync", sda_sync_o, m_d2);
      chk("R2/R3 pulse", bus_rst_o, m_pulse);
      chk("R4 release", sda_rel_o, m_rel);
      if (bus_rst_o) n_pulse++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(input int periods);
    for (int i = 0; i < periods; i++) begin
      scl_i = 1'b0; sda_i = i[0]; wait_cyc(10);
      scl_i = 1'b1; wait_cyc(10);
    end
  endtask

  task automatic low_run(input int n);
    scl_i = 1'b0; wait_cyc(n);
    scl_i = 1'b1; wait_cyc(8);
  endtask

  initial begin
    int p0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R7 reset state
    chk("R7 pulse after reset", bus_rst_o, 0);
    chk("R7 release after reset", sda_rel_o, 0);
    chk("R7 scl sync after reset", scl_sync_o, 1);
    chk("R7 sda sync after reset", sda_sync_o, 1);

    // normal traffic: no timeout
    p0 = n_pulse; toggle(30);
    chk("R2 no pulse on normal clocking", n_pulse - p0, 0);

    // boundary: exactly LIM low cycles
    p0 = n_pulse; low_run(LIM);
    chk("R2 low run of LIM gives no pulse", n_pulse - p0, 0);

    // LIM+1 low cycles
    p0 = n_pulse; low_run(LIM + 1);
    chk("R2 low run of LIM+1 gives one pulse", n_pulse - p0, 1);

    // long hold: saturation, single pulse, release held while low
    p0 = n_pulse; scl_i = 1'b0; wait_cyc(2000);
    chk("R3 single pulse on long hold", n_pulse - p0, 1);
    chk("R4 release held while low", sda_rel_o, 1);
    scl_i = 1'b1; wait_cyc(4);
    chk("R4 release cleared after scl high", sda_rel_o, 0);

    // R8 re-arm: second event
    p0 = n_pulse; low_run(LIM + 20);
    chk("R8 new event after scl high", n_pulse - p0, 1);

    // R6 restart on high: two runs of LIM with short high
    p0 = n_pulse;
    scl_i = 1'b0; wait_cyc(LIM); scl_i = 1'b1; wait_cyc(2);
    scl_i = 1'b0; wait_cyc(LIM); scl_i = 1'b1; wait_cyc(6);
    chk("R6 count restarts on scl high", n_pulse - p0, 0);

    // R5 disabled
    to_dis = 1'b1; p0 = n_pulse;
    low_run(3 * LIM);
    chk("R5 no pulse while disabled", n_pulse - p0, 0);
    chk("R5 no release while disabled", sda_rel_o, 0);
    to_dis = 1'b0; wait_cyc(4);

    // R9 disable during release, re-enable while still low
    p0 = n_pulse; scl_i = 1'b0; wait_cyc(LIM + 10);
    chk("R9 release active before disable", sda_rel_o, 1);
    to_dis = 1'b1; wait_cyc(2);
    chk("R9 release dropped by disable", sda_rel_o, 0);
    to_dis = 1'b0; wait_cyc(LIM + 30);
    chk("R9 no second pulse same event", n_pulse - p0, 1);
    scl_i = 1'b1; wait_cyc(6);

    // collision: disable raised in the cycle the timeout would fire
    p0 = n_pulse; scl_i = 1'b0; wait_cyc(LIM + 1);
    to_dis = 1'b1; wait_cyc(4);
    to_dis = 1'b0; scl_i = 1'b1; wait_cyc(6);
    chk("R5 disable at threshold cycle", n_pulse - p0, 0);

    toggle(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule